// File: doc/BRIEF.md
# Two-Bank Survivor Decision Store

This block holds the per-step decision words produced by the add-compare-select stage of a trellis decoder. It has two banks of equal depth. During any block period one bank takes the incoming decisions and the other is read back for traceback, and the two banks swap roles at every block boundary. This lets decisions stream in without a pause while traceback works on the previous block.

After preset the controller waits in an idle state. A start pulse begins a single fill period, in which only the first bank is loaded. After that the controller alternates between two steady phases. In the first, bank A is read and bank B is written. In the second, bank B is read and bank A is written. Writes advance upward through the addresses. Reads walk the other bank downward, so traceback meets the newest decision first. Read data is registered. A strobe marks the final cycle of every block.

Top module: `survivor_pingpong`

## Requirements
- R1: Asserting `preset` at any time forces the idle phase at once, with `rd_data` = 0, `rd_addr` = DEPTH-1 (15 by default) and `blk_strobe` = 0.
- R2: In the idle phase the block stays idle until `start` is sampled high at a clock edge. While it stays idle, `blk_strobe` remains 0 and `rd_addr` remains DEPTH-1.
- R3: The first block after start is a fill period. The word on `dec_word` in position j (j = 0 for the first cycle) is stored in bank A at address j. No bank is read, so `rd_data` stays 0 throughout the fill.
- R4: After the fill, each block is written to one bank and read from the other, and the banks swap at every boundary. During block k (k ≥ 1), the reads return the words of block k-1 in reverse order of arrival.
- R5: In every non-idle cycle at block position j, `rd_addr` equals DEPTH-1-j, counting down across the block.
- R6: The word at `rd_addr` in a read cycle appears on `rd_data` one clock later. In a cycle that reads no bank, `rd_data` is loaded with 0.
- R7: `blk_strobe` is high exactly in the last cycle (position DEPTH-1) of every non-idle block, and the next cycle starts again at `rd_addr` = DEPTH-1.
- R8: `start` has no effect outside the idle phase.
- R9: A bank is never written and read in the same cycle, so the writes of the current block never disturb the data being traced back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| preset | input | 1 | Asynchronous active-high preset to the idle phase |
| start | input | 1 | Begins the fill period when sampled in the idle phase |
| dec_word | input | WORD_W | Decision word written in the current cycle |
| rd_data | output | WORD_W | Registered traceback read data |
| rd_addr | output | ADDR_W | Traceback read address, counting down |
| blk_strobe | output | 1 | High during the last cycle of each block |

## Verification
The assertions assume that the source delivers exactly one decision word in every cycle of a non-idle block, with no stalls. The traceback side is assumed to consume `rd_data` in the cycle after the address is shown. Release of `preset` is assumed to be synchronous to the clock. The stimulus changes every input only on the falling edge, and it supplies a fresh word in every block cycle. It raises `start` once per run, apart from one deliberate burst in the middle of a run. It asserts `preset` only on a falling edge and then clears all pending expectations before restarting.

// File: rtl/svm_pkg.sv
package svm_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_FILL = 2'd1,
      PH_RDA  = 2'd2,
      PH_RDB  = 2'd3
   } phase_e;

   typedef struct packed {
      logic we_a;
      logic re_a;
      logic we_b;
      logic re_b;
   } bank_ctl_t;

   localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/svm_ctrl.sv
module svm_ctrl
   import svm_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              preset,
   input  logic              start,
   output phase_e            phase,
   output logic [ADDR_W-1:0] pos,
   output bank_ctl_t         ctl,
   output logic              last
);

   localparam logic [ADDR_W-1:0] POS_MAX = {ADDR_W{1'b1}};

   phase_e phase_nx;

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE: if (start)          phase_nx = PH_FILL;
         PH_FILL: if (pos == POS_MAX) phase_nx = PH_RDA;
         PH_RDA:  if (pos == POS_MAX) phase_nx = PH_RDB;
         PH_RDB:  if (pos == POS_MAX) phase_nx = PH_RDA;
         default:                     phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or posedge preset) begin
      if (preset) begin
         phase <= PH_IDLE;
         pos   <= '0;
      end else begin
         phase <= phase_nx;
         if (phase != PH_IDLE) pos <= pos + 1'b1;
         else                  pos <= '0;
      end
   end

   always_comb begin
      ctl = '0;
      unique case (phase)
         PH_FILL: ctl.we_a = 1'b1;
         PH_RDA:  begin ctl.re_a = 1'b1; ctl.we_b = 1'b1; end
         PH_RDB:  begin ctl.we_a = 1'b1; ctl.re_b = 1'b1; end
         default: ctl = '0;
      endcase
   end

   assign last = (phase != PH_IDLE) && (pos == POS_MAX);

   assert_idle_holds_R2: assert property (@(posedge clk) disable iff (preset)
      (phase == PH_IDLE && !start) |=> (phase == PH_IDLE));

   assert_fill_then_rda_R4: assert property (@(posedge clk) disable iff (preset)
      (phase == PH_FILL && pos == POS_MAX) |=> (phase == PH_RDA));

   assert_rda_then_rdb_R4: assert property (@(posedge clk) disable iff (preset)
      (phase == PH_RDA && pos == POS_MAX) |=> (phase == PH_RDB));

   assert_rdb_then_rda_R4: assert property (@(posedge clk) disable iff (preset)
      (phase == PH_RDB && pos == POS_MAX) |=> (phase == PH_RDA));

   assert_pos_steps_R5: assert property (@(posedge clk) disable iff (preset)
      (phase != PH_IDLE) |=> (pos == ADDR_W'($past(pos) + 1'b1)));

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (preset)
      (phase != PH_IDLE) |=> (phase != PH_IDLE));

endmodule

// File: rtl/svm_bank.sv
module svm_bank #(
   parameter int unsigned WORD_W = 4,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/survivor_pingpong.sv
module survivor_pingpong
   import svm_pkg::*;
#(
   parameter int unsigned WORD_W = 4,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              preset,
   input  logic              start,
   input  logic [WORD_W-1:0] dec_word,
   output logic [WORD_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              blk_strobe
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("survivor_pingpong: DEPTH must be a power of two, at least 2");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("survivor_pingpong: WORD_W must be at least 1");
   end

   phase_e            phase;
   logic [ADDR_W-1:0] pos;
   bank_ctl_t         ctl;
   logic              last;

   svm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk    (clk),
      .preset (preset),
      .start  (start),
      .phase  (phase),
      .pos    (pos),
      .ctl    (ctl),
      .last   (last)
   );

   logic [NUM_BANKS-1:0] we_v;
   logic [NUM_BANKS-1:0] re_v;
   logic [WORD_W-1:0]    bank_q [NUM_BANKS];
   logic [ADDR_W-1:0]    waddr;
   logic [ADDR_W-1:0]    raddr;

   assign we_v  = {ctl.we_b, ctl.we_a};
   assign re_v  = {ctl.re_b, ctl.re_a};
   assign waddr = pos;
   assign raddr = ~pos;

   for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
      svm_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
         .clk   (clk),
         .we    (we_v[gi]),
         .waddr (waddr),
         .wdata (dec_word),
         .raddr (raddr),
         .rdata (bank_q[gi])
      );
   end

   always_ff @(posedge clk or posedge preset) begin
      if (preset)        rd_data <= '0;
      else if (re_v[0])  rd_data <= bank_q[0];
      else if (re_v[1])  rd_data <= bank_q[1];
      else               rd_data <= '0;
   end

   assign rd_addr    = raddr;
   assign blk_strobe = last;

   assert_bank_rw_apart_R9: assert property (@(posedge clk) disable iff (preset)
      ((we_v & re_v) == '0) && $onehot0(we_v) && $onehot0(re_v));

   assert_no_read_zero_R6: assert property (@(posedge clk) disable iff (preset)
      (re_v == '0) |=> (rd_data == '0));

   assert_fill_no_read_R3: assert property (@(posedge clk) disable iff (preset)
      (phase == PH_FILL) |-> (re_v == '0));

   assert_strobe_reload_R7: assert property (@(posedge clk) disable iff (preset)
      blk_strobe |=> (rd_addr == {ADDR_W{1'b1}}));

endmodule

// File: tb/survivor_pingpong_tb.sv
`timescale 1ns/1ps
module survivor_pingpong_tb;

   localparam int WORD_W = 4;
   localparam int DEPTH  = 16;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              preset = 1'b1;
   logic              start = 1'b0;
   logic [WORD_W-1:0] dec_word = '0;
   logic [WORD_W-1:0] rd_data;
   logic [ADDR_W-1:0] rd_addr;
   logic              blk_strobe;

   int checks = 0;
   int fails  = 0;
   int exp_q[$];

   always #2.5 clk = ~clk;

   survivor_pingpong #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_dut (
      .clk        (clk),
      .preset     (preset),
      .start      (start),
      .dec_word   (dec_word),
      .rd_data    (rd_data),
      .rd_addr    (rd_addr),
      .blk_strobe (blk_strobe)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [WORD_W-1:0] wgen(input int b, input int j);
      if (b == 3) return '1;
      if (b == 4) return (j % 2 == 0) ? 4'h0 : 4'hA;
      return WORD_W'(((j * 5) + (b * 3) + ((b >> 1) * j)) ^ b);
   endfunction

   // monitor: read data appears one clock after the read cycle (R6)
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         int e;
         e = exp_q.pop_front();
         check(rd_data == WORD_W'(e), "R4/R6 rd_data", int'(rd_data), e);
      end
   end

   task automatic begin_run();
      @(negedge clk);
      start = 1'b1;
   endtask

   // driver: one block of DEPTH words; b is block index within the run
   task automatic run_block(input int tag, input int b, input bit glitch);
      for (int j = 0; j < DEPTH; j++) begin
         @(negedge clk);
         start    = glitch && (j >= 4) && (j < 8);   // R8 burst
         dec_word = wgen(tag + b, j);
         check(rd_addr == ADDR_W'(DEPTH - 1 - j), "R5 rd_addr", int'(rd_addr), DEPTH - 1 - j);
         check(blk_strobe == (j == DEPTH - 1), "R7 blk_strobe", int'(blk_strobe), int'(j == DEPTH - 1));
         if (b == 0) exp_q.push_back(0);              // R3 fill: no read
         else        exp_q.push_back(int'(wgen(tag + b - 1, DEPTH - 1 - j)));
      end
   endtask

   task automatic do_preset();
      @(negedge clk);
      exp_q.delete();
      preset = 1'b1;
      start  = 1'b0;
      #1;
      check(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
      check(rd_addr == ADDR_W'(DEPTH - 1), "R1 rd_addr", int'(rd_addr), DEPTH - 1);
      check(blk_strobe == 1'b0, "R1 blk_strobe", int'(blk_strobe), 0);
      @(negedge clk);
      preset = 1'b0;
   endtask

   task automatic idle_wait(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(blk_strobe == 1'b0, "R2 idle strobe", int'(blk_strobe), 0);
         check(rd_addr == ADDR_W'(DEPTH - 1), "R2 idle rd_addr", int'(rd_addr), DEPTH - 1);
         check(rd_data == '0, "R2 idle rd_data", int'(rd_data), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      do_preset();
      idle_wait(6);
      // first run: fill plus four alternating blocks, start burst in one
      begin_run();
      run_block(0, 0, 1'b0);
      run_block(0, 1, 1'b0);
      run_block(0, 2, 1'b1);
      run_block(0, 3, 1'b0);
      run_block(0, 4, 1'b0);
      // preset in the middle of a running block (R1)
      repeat (5) @(negedge clk);
      do_preset();
      idle_wait(4);
      // second run: fresh data must replace the old bank contents
      begin_run();
      run_block(10, 0, 1'b0);
      run_block(10, 1, 1'b0);
      run_block(10, 2, 1'b0);
      @(negedge clk);
      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule